// File: doc/BRIEF.md
# Split 64-bit Register Access Bridge

This bridge gives a 32-bit register bus access to a small bank of 64-bit registers. Each 64-bit register takes two adjacent word slots, at byte offsets 0x0 and 0x4 from its base. Software writes a full value by first writing the word at offset 0x0, which is only parked in a shared staging register. It then writes the word at offset 0x4, which joins both halves and updates all 64 bits on one clock edge. A register therefore never shows a half-updated value.

Reads have the matching guarantee. A read of the offset 0x0 word also takes a snapshot of the other half. The next read of offset 0x4 for the same register returns that snapshot, not the live value, so a 64-bit counter whose carry crosses bit 32 between the two reads still reads back as one consistent value. A strap input picks which slot holds the most-significant half.

Register 0 is a control register with a self-clearing soft-reset bit. The last register is a free-running counter that software can load. The registers in between are plain storage. Every register is also driven out of the block in parallel.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, every register output, the soft-reset output and the read-valid output are 0, and bus_ready is 1.
- R2: A write to offset 0x0 (bus_addr bit 2 = 0) changes no register output. The word is only staged.
- R3: A write to offset 0x4 (bus_addr bit 2 = 1) of register n = bus_addr[ADDR_W-1:3] updates all 64 bits of that register on the accepting clock edge.
- R4: With order_swap = 0, offset 0x0 holds bits 63..32 and offset 0x4 holds bits 31..0, for both writes and reads.
- R5: With order_swap = 1, offset 0x0 holds bits 31..0 and offset 0x4 holds bits 63..32, for both writes and reads.
- R6: The staging register is cleared by every commit. A write to offset 0x4 with nothing staged commits zeros in the other half.
- R7: A read of offset 0x0 returns that half of the register and snapshots the other half. The next read of offset 0x4 of the same register returns the snapshot, even if the register has changed in the meantime.
- R8: A read of offset 0x4 with no snapshot pending for that register returns the live half. Any read of offset 0x4 discards the snapshot.
- R9: A commit to register 0 with bit 31 of its least-significant half set drives soft_rst high for exactly one cycle. The stored value keeps bit 31 at 0.
- R10: The last register increases by 1 on every edge where cnt_inc is 1 and no commit hits it, holds its value while cnt_inc is 0, and takes the committed value on a commit.
- R11: Each accepted read is answered with bus_rvalid high and bus_rdata valid in the following cycle. No other cycle has bus_rvalid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| order_swap | input | 1 | Strap: 1 puts the least-significant half at offset 0x0 |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bit 2 selects the word, the bits above it select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response valid |
| cnt_inc | input | 1 | Increment enable for the counter register |
| reg_q | output | 64*NUM_REGS | All registers, register n at bits [64n+63:64n] |
| soft_rst | output | 1 | One-cycle soft-reset pulse |

## Verification
The bench loads the counter just below the 32-bit boundary. It reads the upper half, lets the carry ripple across bit 32, then reads the lower half. A bridge without the snapshot returns the post-carry low word and so a torn value. A lone high-word write after a completed pair shows whether staging is cleared: a design that keeps stale staging commits the old half again. The strap is flipped to check that both the joining of halves on write and the choice of half on read follow it. The soft-reset bit is checked both for its single-cycle pulse and for reading back as 0; a design that stores the bit or stretches the pulse fails either check.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

  localparam int WORD_W = 32;
  localparam int DWORD_W = 64;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [DWORD_W-1:0] dword_t;

  // Join the two bus words into one 64-bit value.
  // off0 is the word written at offset 0x0, off4 the word at offset 0x4.
  function automatic dword_t join_halves(input word_t off0, input word_t off4,
                                         input logic swap);
    dword_t v;
    if (swap) v = {off4, off0};
    else      v = {off0, off4};
    return v;
  endfunction

  // Select the half of a 64-bit value that appears at a word slot.
  // hi_slot = 0 selects offset 0x0, hi_slot = 1 selects offset 0x4.
  function automatic word_t pick_half(input dword_t v, input logic hi_slot,
                                      input logic swap);
    word_t w;
    if ((hi_slot ^ swap) == 1'b0) w = v[DWORD_W-1:WORD_W];
    else                          w = v[WORD_W-1:0];
    return w;
  endfunction

endpackage

// File: rtl/wrb_decode.sv
module wrb_decode #(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2,
  parameter int ADDR_W   = 5
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              stage_we,
  output logic              commit_we,
  output logic              rd_req,
  output logic              rd_hi,
  output logic [IDX_W-1:0]  idx
);

  logic unused_byte_bits;
  logic in_range;

  assign unused_byte_bits = ^bus_addr[1:0];

  always_comb begin
    idx       = bus_addr[ADDR_W-1:3];
    in_range  = (int'(idx) < NUM_REGS);
    rd_hi     = bus_addr[2];
    stage_we  = bus_valid & bus_write & ~bus_addr[2] & in_range;
    commit_we = bus_valid & bus_write &  bus_addr[2] & in_range;
    rd_req    = bus_valid & ~bus_write;
  end

endmodule

// File: rtl/wrb_stage.sv
module wrb_stage
  import wrb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stage_we,
  input  logic   commit_we,
  input  logic   swap,
  input  word_t  wdata,
  output dword_t commit_data
);

  word_t stage_q;
  word_t stage_d;
  logic  stage_en;

  // next state: a commit empties the staging word, a low write fills it
  always_comb begin
    stage_en = stage_we | commit_we;
    if (commit_we) stage_d = '0;
    else           stage_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end

  // the high write joins the staged word with its own data
  always_comb begin
    commit_data = join_halves(stage_q, wdata, swap);
  end

endmodule

// File: rtl/wrb_bank.sv
module wrb_bank
  import wrb_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2,
  parameter int SRST_BIT = 31
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit_we,
  input  logic [IDX_W-1:0]          idx,
  input  dword_t                    commit_data,
  input  logic                      cnt_inc,
  output logic [NUM_REGS*DWORD_W-1:0] reg_q,
  output logic                      soft_rst
);

  localparam int CNT_IDX = NUM_REGS - 1;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic   hit;
    dword_t val_q;
    dword_t val_d;
    logic   val_en;

    assign hit = commit_we && (idx == IDX_W'(i));

    if (i == 0) begin : g_ctrl
      logic pulse_q;
      logic pulse_d;

      always_comb begin
        val_en          = hit;
        val_d           = commit_data;
        val_d[SRST_BIT] = 1'b0;
        pulse_d         = hit & commit_data[SRST_BIT];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_d;
      end

      assign soft_rst = pulse_q;
    end else if (i == CNT_IDX) begin : g_count
      always_comb begin
        val_en = hit | cnt_inc;
        if (hit) val_d = commit_data;
        else     val_d = val_q + dword_t'(1);
      end
    end else begin : g_plain
      always_comb begin
        val_en = hit;
        val_d  = commit_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '0;
      else if (val_en) val_q <= val_d;
    end

    assign reg_q[i*DWORD_W +: DWORD_W] = val_q;
  end

endmodule

// File: rtl/wrb_readback.sv
module wrb_readback
  import wrb_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req,
  input  logic                        rd_hi,
  input  logic [IDX_W-1:0]            idx,
  input  logic                        swap,
  input  logic [NUM_REGS*DWORD_W-1:0] reg_q,
  output word_t                       rdata,
  output logic                        rvalid
);

  dword_t           live;
  word_t            shadow_q, shadow_d;
  logic             shadow_vld_q, shadow_vld_d;
  logic [IDX_W-1:0] shadow_idx_q, shadow_idx_d;
  word_t            rdata_q, rdata_d;
  logic             rvalid_q;
  logic             snap_en;
  logic             shadow_hit;

  always_comb begin
    if (int'(idx) < NUM_REGS) live = reg_q[int'(idx)*DWORD_W +: DWORD_W];
    else                      live = '0;
  end

  // next state of the snapshot and the response word
  always_comb begin
    shadow_hit   = shadow_vld_q && (shadow_idx_q == idx);
    snap_en      = rd_req;
    shadow_d     = shadow_q;
    shadow_idx_d = shadow_idx_q;
    shadow_vld_d = shadow_vld_q;
    if (!rd_hi) begin
      rdata_d      = pick_half(live, 1'b0, swap);
      shadow_d     = pick_half(live, 1'b1, swap);
      shadow_idx_d = idx;
      shadow_vld_d = 1'b1;
    end else begin
      rdata_d      = shadow_hit ? shadow_q : pick_half(live, 1'b1, swap);
      shadow_vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q     <= '0;
      shadow_idx_q <= '0;
      shadow_vld_q <= 1'b0;
      rdata_q      <= '0;
    end else if (snap_en) begin
      shadow_q     <= shadow_d;
      shadow_idx_q <= shadow_idx_d;
      shadow_vld_q <= shadow_vld_d;
      rdata_q      <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rd_req;
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = $clog2(NUM_REGS) + 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        order_swap,
  input  logic                        bus_valid,
  output logic                        bus_ready,
  input  logic                        bus_write,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        bus_rvalid,
  input  logic                        cnt_inc,
  output logic [NUM_REGS*64-1:0]      reg_q,
  output logic                        soft_rst
);

  localparam int IDX_W = ADDR_W - 3;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             stage_we, commit_we, rd_req, rd_hi;
  logic [IDX_W-1:0] idx;
  dword_t           commit_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign bus_ready = 1'b1;

  wrb_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .stage_we  (stage_we),
    .commit_we (commit_we),
    .rd_req    (rd_req),
    .rd_hi     (rd_hi),
    .idx       (idx)
  );

  wrb_stage u_stage (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .stage_we    (stage_we),
    .commit_we   (commit_we),
    .swap        (order_swap),
    .wdata       (bus_wdata),
    .commit_data (commit_data)
  );

  wrb_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .commit_we   (commit_we),
    .idx         (idx),
    .commit_data (commit_data),
    .cnt_inc     (cnt_inc),
    .reg_q       (reg_q),
    .soft_rst    (soft_rst)
  );

  wrb_readback #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_readback (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rd_req (rd_req),
    .rd_hi  (rd_hi),
    .idx    (idx),
    .swap   (order_swap),
    .reg_q  (reg_q),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
  parameter int NUM_REGS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic [2:2]             addr_word,
  input logic                   bus_rvalid,
  input logic                   cnt_inc,
  input logic [NUM_REGS*64-1:0] reg_q,
  input logic                   soft_rst
);

  localparam int CNT_LO = (NUM_REGS - 1) * 64;

  // R9
  soft_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  // R9
  ctrl_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q[31] == 1'b0);

  // R2
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !addr_word[2]) |=> $stable(reg_q[CNT_LO-1:0]));

  // R11
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  // R11
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_valid && bus_write) && cnt_inc) |=>
      (reg_q[CNT_LO +: 64] == $past(reg_q[CNT_LO +: 64]) + 64'd1));

endmodule

bind wide_reg_bridge wrb_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .addr_word  (bus_addr[2:2]),
  .bus_rvalid (bus_rvalid),
  .cnt_inc    (cnt_inc),
  .reg_q      (reg_q),
  .soft_rst   (soft_rst)
);

// File: tb/wide_reg_bridge_bench.sv
module wide_reg_bridge_bench;

  localparam int NUM_REGS = 4;
  localparam int ADDR_W   = 5;
  localparam int NVEC     = 15;

  logic                   clk;
  logic                   rst_n;
  logic                   order_swap;
  logic                   bus_valid;
  logic                   bus_ready;
  logic                   bus_write;
  logic [ADDR_W-1:0]      bus_addr;
  logic [31:0]            bus_wdata;
  logic [31:0]            bus_rdata;
  logic                   bus_rvalid;
  logic                   cnt_inc;
  logic [NUM_REGS*64-1:0] reg_q;
  logic                   soft_rst;

  int n_cmp;
  int n_bad;
  bit done;

  wide_reg_bridge #(.NUM_REGS(NUM_REGS)) u_wide_reg_bridge (
    .clk(clk), .rst_n(rst_n), .order_swap(order_swap),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cnt_inc(cnt_inc), .reg_q(reg_q),
    .soft_rst(soft_rst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {write, addr, wdata, expected read data}; default word order
  localparam logic [69:0] VEC [NVEC] = '{
    {1'b1, 5'h08, 32'h11112222, 32'h0},
    {1'b1, 5'h0C, 32'h33334444, 32'h0},
    {1'b0, 5'h08, 32'h0,        32'h11112222},
    {1'b0, 5'h0C, 32'h0,        32'h33334444},
    {1'b1, 5'h14, 32'hDEADBEEF, 32'h0},
    {1'b0, 5'h10, 32'h0,        32'h00000000},
    {1'b0, 5'h14, 32'h0,        32'hDEADBEEF},
    {1'b1, 5'h10, 32'hAAAA5555, 32'h0},
    {1'b0, 5'h08, 32'h0,        32'h11112222},
    {1'b1, 5'h14, 32'h01234567, 32'h0},
    {1'b0, 5'h10, 32'h0,        32'hAAAA5555},
    {1'b0, 5'h14, 32'h0,        32'h01234567},
    {1'b0, 5'h0C, 32'h0,        32'h33334444},
    {1'b0, 5'h08, 32'h0,        32'h11112222},
    {1'b0, 5'h14, 32'h0,        32'h01234567}
  };

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the falling edge after acceptance
  task automatic op(input logic we, input logic [ADDR_W-1:0] a,
                    input logic [31:0] d);
    bus_valid = 1'b1;
    bus_write = we;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    bus_write = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [ADDR_W-1:0] a,
                          input logic [31:0] exp);
    op(1'b0, a, 32'h0);
    check("R11 rvalid", {63'd0, bus_rvalid}, 64'd1);
    check(req, {32'd0, bus_rdata}, {32'd0, exp});
  endtask

  function automatic logic [63:0] rq(input int n);
    return reg_q[n*64 +: 64];
  endfunction

  initial begin : watchdog
    int cyc;
    for (cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [255:0] saved;
    n_cmp = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; order_swap = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0; cnt_inc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 reg_q", reg_q[63:0] | reg_q[127:64] | reg_q[191:128] | reg_q[255:192], 64'd0);
    check("R1 soft_rst", {63'd0, soft_rst}, 64'd0);
    check("R1 rvalid", {63'd0, bus_rvalid}, 64'd0);
    check("R1 ready", {63'd0, bus_ready}, 64'd1);

    // table: R3 R4 R6 R7 R8 in default order
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][69]) op(1'b1, VEC[i][68:64], VEC[i][63:32]);
      else rd_check("R4/R7/R8 table read", VEC[i][68:64], VEC[i][31:0]);
    end
    check("R3 reg1", rq(1), 64'h11112222_33334444);
    check("R6 reg2", rq(2), 64'hAAAA5555_01234567);

    // R2 staged write leaves the bank untouched
    saved = reg_q;
    op(1'b1, 5'h10, 32'h77777777);
    check("R2 stage only", {63'd0, (reg_q == saved)}, 64'd1);
    op(1'b1, 5'h14, 32'h00000000);
    check("R3 commit", rq(2), 64'h77777777_00000000);
    op(1'b1, 5'h14, 32'h00000005);
    check("R6 staging cleared", rq(2), 64'h00000000_00000005);

    // R5 swapped word order
    order_swap = 1'b1;
    op(1'b1, 5'h08, 32'hCAFEF00D);
    op(1'b1, 5'h0C, 32'h0BADC0DE);
    check("R5 swap commit", rq(1), 64'h0BADC0DE_CAFEF00D);
    rd_check("R5 swap read off0", 5'h08, 32'hCAFEF00D);
    rd_check("R5 swap read off4", 5'h0C, 32'h0BADC0DE);
    order_swap = 1'b0;

    // R9 soft reset
    op(1'b1, 5'h00, 32'h00000000);
    op(1'b1, 5'h04, 32'h80000005);
    check("R9 pulse high", {63'd0, soft_rst}, 64'd1);
    check("R9 bit cleared", rq(0), 64'h00000000_00000005);
    @(negedge clk);
    check("R9 pulse one cycle", {63'd0, soft_rst}, 64'd0);

    // R10 counter load and count
    op(1'b1, 5'h18, 32'h00000000);
    op(1'b1, 5'h1C, 32'hFFFFFFFE);
    check("R10 load", rq(3), 64'h00000000_FFFFFFFE);
    cnt_inc = 1'b1;
    repeat (3) @(negedge clk);
    cnt_inc = 1'b0;
    check("R10 count", rq(3), 64'h00000001_00000001);
    repeat (2) @(negedge clk);
    check("R10 hold", rq(3), 64'h00000001_00000001);

    // R7 coherent read across the carry
    op(1'b1, 5'h18, 32'h00000000);
    op(1'b1, 5'h1C, 32'hFFFFFFFE);
    rd_check("R7 counter high", 5'h18, 32'h00000000);
    cnt_inc = 1'b1;
    repeat (5) @(negedge clk);
    cnt_inc = 1'b0;
    rd_check("R7 counter snapshot low", 5'h1C, 32'hFFFFFFFE);
    rd_check("R8 counter live low", 5'h1C, 32'h00000003);
    rd_check("R7 counter high after carry", 5'h18, 32'h00000001);

    // R11 a write gives no read response
    op(1'b1, 5'h08, 32'h0);
    check("R11 no rvalid on write", {63'd0, bus_rvalid}, 64'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule